// File: doc/BRIEF.md
# Fixed Off-Time PWM Current Chopper

This block regulates winding current for one full bridge by controlling three drive signals: a high-side source enable, a fast-decay request and a slow-decay request. In internal mode the bridge conducts until an analog comparator reports that the current has reached its trip level. The source driver is then switched off for a programmable fixed off-time. During that time the winding recirculates through either slow decay alone, or through mixed decay: fast decay for a programmable leading portion, then slow decay for the rest. When the off-time ends, conduction resumes. For one oscillator tick after that, a trip flag that is still asserted is ignored, so the comparator has time to settle.

In external mode the internal timer has no role. An external enable chops the bridge directly. While that enable is low, the block applies the decay type selected for external operation. All timing is counted in ticks of the internal oscillator, which arrive as single-cycle pulses on `osc_tick`. The system clock is only the sampling clock. `rst_n` is asynchronous and active low, and its release is expected to be synchronized upstream.

Top module: `fot_chopper`

## Requirements
- R1: While `rst_n` is low, and right after it is released, the block is in the conducting phase: `src_en`=1, `fast_dec`=0, `slow_dec`=0.
- R2: In internal mode (`ext_mode`=0), the phase changes only on a cycle with `osc_tick`=1. A conducting phase ends (`src_en` goes to 0) on a tick where `trip`=1 and the blanking tick has already passed.
- R3: The off phase lasts exactly (N+1)*8-1 oscillator ticks, where N is the unsigned 5-bit `toff_code`. After that, `src_en` returns to 1.
- R4: With `mix_sel`=1 (mixed), `fast_dec`=1 for the first (F+1)*8 ticks of the off phase, where F is the unsigned 4-bit `tfd_code`. `slow_dec`=1 for the remaining ticks.
- R5: With `mix_sel`=1 and (F+1)*8 >= (N+1)*8-1, `fast_dec`=1 for the whole off phase and `slow_dec` never rises.
- R6: With `mix_sel`=0 (slow), `slow_dec`=1 for the whole off phase and `fast_dec` stays 0.
- R7: On the first tick after the off phase ends, `trip` is ignored and `src_en` stays 1. On the following tick, a high `trip` starts a new off phase.
- R8: With `ext_mode`=1, `src_en` follows `ext_en` and `trip` has no effect. While `ext_en`=0, `ext_fast`=1 gives `fast_dec`=1, and `ext_fast`=0 gives `slow_dec`=1.
- R9: `fast_dec` and `slow_dec` are never 1 together, and both are 0 whenever `src_en`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| trip | input | 1 | Current-trip comparator flag |
| ext_mode | input | 1 | 1 = external chopping, 0 = internal timer |
| ext_en | input | 1 | External enable / chopping input |
| ext_fast | input | 1 | External-mode decay: 1 fast, 0 slow |
| mix_sel | input | 1 | Internal-mode decay: 1 mixed, 0 slow |
| toff_code | input | 5 | Off-time code N |
| tfd_code | input | 4 | Fast-decay length code F |
| src_en | output | 1 | Source driver enable |
| fast_dec | output | 1 | Fast-decay request |
| slow_dec | output | 1 | Slow-decay request |

## Verification
The bench measures the off phase tick by tick for several code pairs. An off-by-one in the off-time formula would show up as a length of 8N+8 or 8N+6, and a swapped mixed-decay order would report slow ticks before fast ones. The codes at the ends of the range and the case where the fast window is one tick longer than the off-time both target the all-fast fallback; a design that compared the wrong way would emit one stray slow tick. The blanking tick is tested with `trip` held high across the end of the off phase, which would catch a design that re-trips at once. Trip pulses in external mode and trips between oscillator ticks check that neither moves the phase.

// File: rtl/fot_pkg.sv
package fot_pkg;
  typedef enum logic {PH_ON = 1'b0, PH_OFF = 1'b1} phase_e;
  localparam int UNIT_SH = 3;  // durations count in units of 8 ticks
endpackage

// File: rtl/fot_off_timer.sv
module fot_off_timer #(
  parameter int TOFF_W  = 5,
  parameter int TFD_W   = 4,
  parameter int UNIT_SH = fot_pkg::UNIT_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [TOFF_W-1:0] toff_code,
  input  logic [TFD_W-1:0]  tfd_code,
  output logic              done,
  output logic              fast_win
);
  localparam int MAX_W = (TOFF_W > TFD_W) ? TOFF_W : TFD_W;
  localparam int LEN_W = MAX_W + UNIT_SH + 1;

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] off_len, fast_len;

  always_comb begin
    off_len  = ((LEN_W'(toff_code) + LEN_W'(1)) << UNIT_SH) - LEN_W'(1);
    fast_len =  (LEN_W'(tfd_code)  + LEN_W'(1)) << UNIT_SH;
    done     = (cnt_q + LEN_W'(1)) >= off_len;
    fast_win = cnt_q < fast_len;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fot_decay_sel.sv
module fot_decay_sel (
  input  logic ext_mode,
  input  logic ext_en,
  input  logic ext_fast,
  input  logic mix_sel,
  input  logic off_phase,
  input  logic fast_win,
  output logic src_en,
  output logic fast_dec,
  output logic slow_dec
);
  always_comb begin
    src_en   = 1'b1;
    fast_dec = 1'b0;
    slow_dec = 1'b0;
    if (ext_mode) begin
      src_en = ext_en;
      if (!ext_en) begin
        fast_dec = ext_fast;
        slow_dec = !ext_fast;
      end
    end else if (off_phase) begin
      src_en   = 1'b0;
      fast_dec = mix_sel && fast_win;
      slow_dec = !(mix_sel && fast_win);
    end
  end
endmodule

// File: rtl/fot_chopper.sv
module fot_chopper #(
  parameter int TOFF_W = 5,
  parameter int TFD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              trip,
  input  logic              ext_mode,
  input  logic              ext_en,
  input  logic              ext_fast,
  input  logic              mix_sel,
  input  logic [TOFF_W-1:0] toff_code,
  input  logic [TFD_W-1:0]  tfd_code,
  output logic              src_en,
  output logic              fast_dec,
  output logic              slow_dec
);
  import fot_pkg::*;

  phase_e phase_q, phase_d;
  logic   blank_q, blank_d;
  logic   tmr_done, fast_win;
  logic   tmr_clr, tmr_adv;

  assign tmr_clr = (phase_q != PH_OFF);
  assign tmr_adv = osc_tick && (phase_q == PH_OFF);

  fot_off_timer #(.TOFF_W(TOFF_W), .TFD_W(TFD_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tmr_clr),
    .adv      (tmr_adv),
    .toff_code(toff_code),
    .tfd_code (tfd_code),
    .done     (tmr_done),
    .fast_win (fast_win)
  );

  // next-state
  always_comb begin
    phase_d = phase_q;
    blank_d = blank_q;
    if (ext_mode) begin
      phase_d = PH_ON;
      blank_d = 1'b0;
    end else if (osc_tick) begin
      unique case (phase_q)
        PH_ON: begin
          if (blank_q)   blank_d = 1'b0;
          else if (trip) phase_d = PH_OFF;
        end
        PH_OFF: begin
          if (tmr_done) begin
            phase_d = PH_ON;
            blank_d = 1'b1;
          end
        end
        default: phase_d = PH_ON;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ON;
      blank_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      blank_q <= blank_d;
    end
  end

  fot_decay_sel u_sel (
    .ext_mode (ext_mode),
    .ext_en   (ext_en),
    .ext_fast (ext_fast),
    .mix_sel  (mix_sel),
    .off_phase(phase_q == PH_OFF),
    .fast_win (fast_win),
    .src_en   (src_en),
    .fast_dec (fast_dec),
    .slow_dec (slow_dec)
  );
endmodule

// File: rtl/fot_chopper_chk.sv
module fot_chopper_chk (
  input logic clk,
  input logic rst_n,
  input logic osc_tick,
  input logic ext_mode,
  input logic ext_en,
  input logic mix_sel,
  input logic blank,
  input logic src_en,
  input logic fast_dec,
  input logic slow_dec
);
  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fast_dec && slow_dec));

  p_on_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    src_en |-> (!fast_dec && !slow_dec));

  p_ext_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> (src_en == ext_en));

  p_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !$past(ext_mode) && !$past(osc_tick)) |-> (src_en == $past(src_en)));

  p_blank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && osc_tick && !ext_mode) |=> (src_en || ext_mode));

  p_slow_whole_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !src_en && !mix_sel) |-> slow_dec);
endmodule

bind fot_chopper fot_chopper_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .osc_tick(osc_tick),
  .ext_mode(ext_mode),
  .ext_en  (ext_en),
  .mix_sel (mix_sel),
  .blank   (blank_q),
  .src_en  (src_en),
  .fast_dec(fast_dec),
  .slow_dec(slow_dec)
);

// File: tb/fot_chopper_tb_top.sv
`timescale 1ns/1ps
module fot_chopper_tb_top;
  logic clk = 1'b0;
  logic rst_n, osc_tick, trip, ext_mode, ext_en, ext_fast, mix_sel;
  logic [4:0] toff_code;
  logic [3:0] tfd_code;
  logic src_en, fast_dec, slow_dec;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  fot_chopper dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .trip(trip),
    .ext_mode(ext_mode), .ext_en(ext_en), .ext_fast(ext_fast),
    .mix_sel(mix_sel), .toff_code(toff_code), .tfd_code(tfd_code),
    .src_en(src_en), .fast_dec(fast_dec), .slow_dec(slow_dec)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail);
      $finish;
    end
  end

  // columns: N, F, mixed, expected off ticks, expected fast ticks
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{ 0,  0, 1,   7,   7},   // R5 fallback at minimum codes
    '{ 1,  0, 1,  15,   8},   // R4
    '{ 3,  1, 1,  31,  16},   // R4
    '{ 2,  5, 0,  23,   0},   // R6 slow only
    '{15, 15, 1, 127, 127},   // R5 fast window one tick longer
    '{31,  2, 1, 255,  24},   // R3 longest off-time
    '{ 5,  5, 1,  47,  47}    // R5
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) osc_tick = 1'b1;
    @(negedge clk) osc_tick = 1'b0;
  endtask

  task automatic run_off(output int offc, output int fc, output int sc, output int bothc);
    offc = 0; fc = 0; sc = 0; bothc = 0;
    trip = 1'b1;
    tick();
    trip = 1'b0;
    while (src_en == 1'b0 && offc < 400) begin
      offc = offc + 1;
      if (fast_dec) fc = fc + 1;
      if (slow_dec) sc = sc + 1;
      if (fast_dec && slow_dec) bothc = bothc + 1;
      tick();
    end
  endtask

  initial begin
    int offc, fc, sc, bothc;
    rst_n = 1'b0; osc_tick = 1'b0; trip = 1'b0; ext_mode = 1'b0;
    ext_en = 1'b0; ext_fast = 1'b0; mix_sel = 1'b1;
    toff_code = 5'd0; tfd_code = 4'd0;
    repeat (3) @(negedge clk);
    check("R1 reset src_en", int'(src_en), 1);
    check("R1 reset decay", int'(fast_dec) + int'(slow_dec), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release src_en", int'(src_en), 1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      toff_code = 5'(VEC[i][0]);
      tfd_code  = 4'(VEC[i][1]);
      mix_sel   = VEC[i][2][0];
      tick();  // clear any blanking tick
      run_off(offc, fc, sc, bothc);
      check("R3 off length", offc, VEC[i][3]);
      check("R4/R5/R6 fast ticks", fc, VEC[i][4]);
      check("R4/R6 slow ticks", sc, VEC[i][3] - VEC[i][4]);
      check("R9 exclusive decay", bothc, 0);
    end

    // R2: trip without oscillator tick does nothing
    toff_code = 5'd0; tfd_code = 4'd0; mix_sel = 1'b0;
    tick();
    trip = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 no tick no trip", int'(src_en), 1);
    tick();
    check("R2 trip on tick", int'(src_en), 0);
    check("R6 slow after trip", int'(slow_dec), 1);

    // R7: trip held across end of off phase (7 ticks at N=0)
    repeat (7) tick();
    check("R3 back on after 7 ticks", int'(src_en), 1);
    tick();
    check("R7 blanking tick ignores trip", int'(src_en), 1);
    tick();
    check("R7 trip after blanking", int'(src_en), 0);
    trip = 1'b0;

    // R1: asynchronous reset in the middle of the off phase
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R1 async reset src_en", int'(src_en), 1);
    check("R1 async reset decay", int'(fast_dec) + int'(slow_dec), 0);
    @(negedge clk) rst_n = 1'b1;

    // R8: external mode
    ext_mode = 1'b1; ext_en = 1'b1; ext_fast = 1'b1;
    @(negedge clk);
    check("R8 ext enable high", int'(src_en), 1);
    check("R9 ext on quiet", int'(fast_dec) + int'(slow_dec), 0);
    trip = 1'b1;
    tick(); tick();
    check("R8 trip ignored", int'(src_en), 1);
    trip = 1'b0;
    ext_en = 1'b0;
    @(negedge clk);
    check("R8 ext low src_en", int'(src_en), 0);
    check("R8 ext fast", int'(fast_dec), 1);
    check("R8 ext fast no slow", int'(slow_dec), 0);
    ext_fast = 1'b0;
    @(negedge clk);
    check("R8 ext slow", int'(slow_dec), 1);
    check("R8 ext slow no fast", int'(fast_dec), 0);
    ext_mode = 1'b0;
    @(negedge clk);
    check("R8 back to internal on", int'(src_en), 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule